// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

A watchdog peripheral with three 16-bit registers on a simple single-cycle write bus and a combinational read path. Once software sets the enable bit, the block counts down a programmable number of half-second ticks. When the count reaches zero it raises a system reset request for a fixed number of clocks and records the cause in a status register.

Software keeps the system alive by writing a two-word key pair to the service register. An ordinary single write is not enough. Any write that breaks the pair sends the key checker back to its starting point.

The enable bit is sticky. Software can set it but cannot clear it, so only a hardware reset disarms the watchdog. A slow reference pulse, synchronous to the bus clock, is divided by a parameterised prescaler to make the half-second tick.

Top module: `keyed_wdt`

## Requirements
- R1: Registers are decoded from the byte address: control at 0, service at 2, status at 4. In control, bits 0, 1, 3 and 7 are freely writable mode bits and bits 15:8 hold the timeout field N. Control bits 6:4 read zero, and the service register and all unused addresses read zero.
- R2: Writing 1 to control bit 2 enables the watchdog. A later control write with bit 2 at 0 leaves it enabled. Only `rst_n` or `por_n` clears it.
- R3: One tick occurs every TICK_DIV cycles in which `ref_pulse` is high. A write that first enables the watchdog loads N+1 ticks from the same write, so with `ref_pulse` held high the reset request rises on the edge TICK_DIV*(N+1) cycles after the enabling write edge. A disabled watchdog never expires.
- R4: The prescaler advances only in cycles where `ref_pulse` is high, so the countdown stalls while it is low.
- R5: A service write of 0x5555 followed directly by a service write of 0xAAAA reloads N+1 ticks from the current timeout field and restarts the prescaler. With N=0 this gives the minimum timeout of one tick.
- R6: Any service write other than the expected next key returns the checker to waiting for 0x5555 and does not reload. This includes 0x5555 while 0xAAAA is expected, and 0xAAAA without a preceding 0x5555.
- R7: Writing a new timeout field while enabled does not change the running count. The new value applies from the next valid key pair.
- R8: On expiry `rst_req` is high for exactly PULSE_CYCLES clocks. The count then stays at zero and no further request occurs until a reload.
- R9: Status bit 1 is set on expiry. Bus writes do not change it and `rst_n` leaves it set; only `por_n` clears it.
- R10: After `por_n`, control and status read 0 and `rst_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| rst_n | input | 1 | Hardware reset, active low, asynchronous; clears all but the status bit |
| ref_pulse | input | 1 | One-cycle enable from the slow reference clock |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| rst_req | output | 1 | System reset request |

## Verification
The checker watches properties every cycle:
- the enable bit never falls outside reset;
- a service write that is not 0x5555 always leaves the checker disarmed;
- the count never rises except through an enabling write or a reload;
- each rising reset request coincides with a zero count and a set status bit;
- the status bit never clears without a power-on reset.

Exact timing needs the bench's scenarios, which measure cycle counts against TICK_DIV*(N+1) for every timeout value. The same scenarios cover:
- the reset pulse width;
- that broken key orders do not reload;
- that a changed timeout waits for the next key pair;
- that the reference pulse gates progress;
- that no further reset request follows an expiry.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int TICK_DIV     = 16384,
  parameter int PULSE_CYCLES = 16
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        ref_pulse,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        rst_req
);
  localparam int PW  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int PCW = $clog2(PULSE_CYCLES + 1);
  localparam logic [PW-1:0]  PRE_LAST = PW'(TICK_DIV - 1);
  localparam logic [15:0]    KEY_FIRST  = 16'h5555;
  localparam logic [15:0]    KEY_SECOND = 16'hAAAA;

  wire core_rst_n = rst_n & por_n;

  logic          en, armed, tout;
  logic          stop_mode, dbg_mode, out_mode, wait_mode;
  logic [7:0]    tmo;
  logic [8:0]    cnt;
  logic [PW-1:0] pre;
  logic [PCW-1:0] pulse;

  wire wr_ctrl  = bus_wr && bus_addr == 3'd0;
  wire wr_svc   = bus_wr && bus_addr == 3'd2;
  wire enabling = wr_ctrl && !en && bus_wdata[2];
  wire reload   = wr_svc && armed && bus_wdata == KEY_SECOND;
  wire step     = en && ref_pulse && cnt != 9'd0;
  wire tick     = step && (pre == PRE_LAST);
  wire expire   = tick && cnt == 9'd1 && !reload;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      en <= 1'b0;
      tmo <= '0;
      {stop_mode, dbg_mode, out_mode, wait_mode} <= '0;
    end else if (wr_ctrl) begin
      en <= en | bus_wdata[2];
      tmo <= bus_wdata[15:8];
      {stop_mode, dbg_mode, out_mode, wait_mode} <=
        {bus_wdata[0], bus_wdata[1], bus_wdata[3], bus_wdata[7]};
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)
      armed <= 1'b0;
    else if (wr_svc)
      armed <= !armed && bus_wdata == KEY_FIRST;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      cnt <= '0;
      pre <= '0;
    end else if (enabling) begin
      cnt <= {1'b0, bus_wdata[15:8]} + 9'd1;
      pre <= '0;
    end else if (reload) begin
      cnt <= {1'b0, tmo} + 9'd1;
      pre <= '0;
    end else if (step) begin
      if (tick) begin
        pre <= '0;
        cnt <= cnt - 9'd1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)
      pulse <= '0;
    else if (expire)
      pulse <= PCW'(PULSE_CYCLES);
    else if (pulse != '0)
      pulse <= pulse - 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      tout <= 1'b0;
    else if (expire)
      tout <= 1'b1;
  end

  assign rst_req = pulse != '0;

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = {tmo, wait_mode, 3'b000, out_mode, en, dbg_mode, stop_mode};
      3'd4:    bus_rdata = {14'd0, tout, 1'b0};
      default: bus_rdata = 16'd0;
    endcase
  end
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk (
  input logic        clk,
  input logic        por_n,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [2:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic        en,
  input logic        armed,
  input logic [8:0]  cnt,
  input logic        reload,
  input logic        rst_req,
  input logic        tout
);
  assert_en_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    en |=> en);

  assert_bad_key_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_wr && bus_addr == 3'd2 && bus_wdata != 16'h5555) |=> !armed);

  assert_no_stray_reload_R6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (!reload && !(bus_wr && bus_addr == 3'd0)) |=> cnt <= $past(cnt));

  assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(rst_req) |-> (cnt == 9'd0 && tout));

  assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
    tout |=> tout);
endmodule

bind keyed_wdt keyed_wdt_chk u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .en(en), .armed(armed), .cnt(cnt), .reload(reload),
  .rst_req(rst_req), .tout(tout)
);

// File: tb/tb_keyed_wdt.sv
module tb_keyed_wdt;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 2;
  localparam int PULSE = 3;

  logic clk = 0, por_n = 0, rst_n = 0, ref_pulse = 1, bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic rst_req;
  int checks = 0, errors = 0;
  bit done = 0;

  keyed_wdt #(.TICK_DIV(DIV), .PULSE_CYCLES(PULSE)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .ref_pulse(ref_pulse), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, got, got, exp, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    bus_addr = a; #2 v = int'(bus_rdata);
  endtask

  task automatic idle(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (rst_req) hits++;
    end
  endtask

  task automatic measure(input int lim, output int k);
    int n = 0;
    k = -1;
    while (n < lim) begin
      @(posedge clk); #1; n++;
      if (rst_req) begin k = n; break; end
    end
  endtask

  task automatic width(output int w);
    w = 1;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      if (rst_req) w++; else break;
    end
  endtask

  task automatic hw_rst();
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v, k, w, h;
    #(CLK_PERIOD * 2);
    @(negedge clk); por_n = 1; rst_n = 1;
    #1;
    rd(3'd0, v); check("R10 ctrl after por", v, 0);
    rd(3'd4, v); check("R10 status after por", v, 0);
    check("R10 rst_req after por", int'(rst_req), 0);
    rd(3'd2, v); check("R1 service reads zero", v, 0);

    wr(3'd0, 16'h00FB);
    rd(3'd0, v); check("R1 mode bits readback", v, 16'h008B);
    rd(3'd6, v); check("R1 unused address", v, 0);
    idle(40, h); check("R3 disabled never expires", h, 0);

    for (int n = 0; n < 256; n++) begin
      hw_rst();
      wr(3'd0, {n[7:0], 8'h04});
      measure(DIV*(n+1) + 10, k);
      check($sformatf("R3 timeout N=%0d", n), k, DIV*(n+1));
      width(w);
      check($sformatf("R8 pulse width N=%0d", n), w, PULSE);
      if (n == 0) begin
        rd(3'd4, v); check("R9 status set on expiry", v, 2);
        idle(30, h); check("R8 no repeat after expiry", h, 0);
      end
    end

    wr(3'd4, 16'h0000); rd(3'd4, v); check("R9 write 0 ignored", v, 2);
    wr(3'd4, 16'hFFFF); rd(3'd4, v); check("R9 write 1s ignored", v, 2);
    hw_rst(); rd(3'd4, v); check("R9 kept over rst_n", v, 2);
    rd(3'd0, v); check("R2 rst_n clears enable", v, 0);

    hw_rst();
    wr(3'd0, 16'h0004); wr(3'd2, 16'h5555); wr(3'd2, 16'hAAAA);
    measure(20, k); check("R5 minimum timeout after keys", k, DIV);

    hw_rst();
    wr(3'd0, 16'h0304); idle(3, h); wr(3'd2, 16'h5555); wr(3'd2, 16'hAAAA);
    measure(30, k); check("R5 key pair reload N=3", k, DIV*4);

    hw_rst();
    wr(3'd0, 16'h0304); wr(3'd2, 16'h5555); wr(3'd2, 16'h1234); wr(3'd2, 16'hAAAA);
    measure(30, k); check("R6 bad middle word no reload", k, DIV*4 - 3);

    hw_rst();
    wr(3'd0, 16'h0304); wr(3'd2, 16'h5555); wr(3'd2, 16'h5555); wr(3'd2, 16'hAAAA);
    measure(30, k); check("R6 repeated first key no reload", k, DIV*4 - 3);

    hw_rst();
    wr(3'd0, 16'h0304); wr(3'd2, 16'hAAAA);
    measure(30, k); check("R6 lone second key no reload", k, DIV*4 - 1);

    hw_rst();
    wr(3'd0, 16'h0704); wr(3'd0, 16'h0000);
    rd(3'd0, v); check("R2 zero write keeps enable", v, 16'h0004);
    measure(40, k); check("R7 running count unchanged", k, DIV*8 - 1);

    hw_rst();
    wr(3'd0, 16'h0704); wr(3'd0, 16'h0100);
    rd(3'd0, v); check("R2 enable sticky, new field", v, 16'h0104);
    wr(3'd2, 16'h5555); wr(3'd2, 16'hAAAA);
    measure(40, k); check("R7 new field on next reload", k, DIV*2);

    hw_rst();
    ref_pulse = 0;
    wr(3'd0, 16'h0204);
    idle(40, h); check("R4 stalled without ref_pulse", h, 0);
    ref_pulse = 1;
    measure(30, k); check("R4 resumes with ref_pulse", k, DIV*3);

    @(negedge clk); por_n = 0;
    @(posedge clk); #1 por_n = 1;
    rd(3'd4, v); check("R9 por clears status", v, 0);
    check("R10 rst_req low after por", int'(rst_req), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule